// File: doc/BRIEF.md
# PCI Bus-Master Read Sequencer

This block fetches data for a network controller over a 32-bit PCI bus. Local logic starts a job by giving a start address, a dword count and an access class. The class is either control data (init block or descriptors) or transmit buffer. The block then requests the bus and waits for the grant. For each grant it runs one transaction: one address phase followed by one or more data phases. Each dword read is handed back with a one-clock valid strobe.

Whether a job runs as one burst or as a string of single-dword transactions depends on the configuration inputs and the access class. When a job is split, the block gives up the bus after each transaction and arbitrates again for the next dword. The read command is chosen from the access class, the burst decision and a command-select input. A target that never claims the cycle ends the job with a master-abort flag.

Top module: `pci_rd_master`

## Requirements
- R1: After synchronous reset, `req_n`, `frame_n` and `irdy_n` are high, `ad_oe` is low and `busy` is low. A `start` with a non-zero count drives `req_n` low on the next clock.
- R2: The address-phase command on `cbe_n` is 4'b0110 for control-class reads (`start_cls`=0) and for any single-dword read. A burst read of the transmit-buffer class (`start_cls`=1) uses 4'b1110 when `cfg_mult_sel`=0 and 4'b1100 when `cfg_mult_sel`=1.
- R3: In the address phase, `ad_oe` is high, `frame_n` is low and `ad_out` carries the current dword address with bits [1:0] forced to 2'b00. The first address is `start_addr` with its two low bits cleared, and each later address is 4 higher per dword already read.
- R4: `irdy_n` goes low in the clock right after the address phase. While `irdy_n` is low, `cbe_n` is 4'b0000.
- R5: A data phase completes only on a clock where `irdy_n`, `trdy_n` and `devsel_n` are all low, so target wait states stretch the phase. The dword captured from `ad_in` appears on `rd_data` with `rd_valid` high in the following clock, in address order.
- R6: `frame_n` rises when the next-to-last data phase completes, so it is high during exactly the last data phase. In a single-phase transaction, `frame_n` is low only during the address phase.
- R7: A job bursts all its dwords in one transaction only when `cfg_burst_en`=1 and either `start_cls`=1 or `cfg_desc_burst`=1. Otherwise each dword is a separate transaction with its own address phase.
- R8: Each grant carries exactly one transaction. When the last data phase completes, `irdy_n` and `req_n` go high. If dwords remain, `req_n` goes low again one clock later.
- R9: With `cfg_ext_req`=0, `req_n` goes high in the same clock that `frame_n` first goes low. With `cfg_ext_req`=1, `req_n` stays low until the last data phase completes.
- R10: One clock after the address phase, `par_oe` is high and `par` equals the XOR of the address-phase `ad_out` and `cbe_n`, which gives even parity.
- R11: If `devsel_n` has not been sampled low by the fifth clock counted from the clock in which `frame_n` went low, the block releases the bus. It then pulses `mabort` in the clock after that fifth clock, returns to idle and returns no data.
- R12: When the last dword of a job has been returned, `done` pulses for one clock and `busy` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a job (taken when idle) |
| start_addr | input | 32 | Byte address of the first dword |
| start_count | input | CNT_W | Number of dwords to read |
| start_cls | input | 1 | 0 control data, 1 transmit buffer |
| cfg_burst_en | input | 1 | Burst reads permitted |
| cfg_desc_burst | input | 1 | Control-class reads may burst |
| cfg_mult_sel | input | 1 | Transmit burst command select |
| cfg_ext_req | input | 1 | Hold request through the transaction |
| busy | output | 1 | Job in progress |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | FRAME, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| cbe_n | output | 4 | Command / byte enables |
| ad_out | output | 32 | Address driven in address phase |
| ad_oe | output | 1 | Enable for `ad_out` |
| ad_in | input | 32 | Read data from the bus |
| par | output | 1 | Address-phase parity |
| par_oe | output | 1 | Enable for `par` |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| rd_data | output | 32 | Returned dword |
| rd_valid | output | 1 | `rd_data` strobe |
| done | output | 1 | Job finished |
| mabort | output | 1 | Job ended by master abort |

## Verification
Two pairs of events can land in the same clock. When the next-to-last data phase completes, `frame_n` must rise at the very edge where the data strobe is produced. When there is no wait state, that completion also falls in the clock right after the address phase, where `irdy_n` and DEVSEL sampling begin. A sweep over class, configuration, count (1 to 3) and wait states (0 or 1) provokes both cases, and the bench counts the number of last-phase completions seen with FRAME already high against the expected number of transactions. The DEVSEL deadline is hit from both sides, with a target that claims in the last allowed clock and one that claims a clock too late, and the bench judges the clock in which the abort appears.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_ARB, ST_ADDR, ST_DATA, ST_TURN} mst_state_t;
  localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
endpackage

// File: rtl/pci_rd_cmd_sel.sv
module pci_rd_cmd_sel
  import pci_rd_pkg::*;
(
  input  logic       cls_tx,
  input  logic       cfg_burst_en,
  input  logic       cfg_desc_burst,
  input  logic       cfg_mult_sel,
  input  logic       multi_dword,
  output logic       burst_ok,
  output logic [3:0] cmd
);
  always_comb begin
    burst_ok = cfg_burst_en && (cls_tx || cfg_desc_burst);
    if (burst_ok && cls_tx && multi_dword)
      cmd = cfg_mult_sel ? CMD_MEM_RD_MULT : CMD_MEM_RD_LINE;
    else
      cmd = CMD_MEM_RD;
  end
endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] be,
  input  logic            drive,
  output logic            par,
  output logic            par_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      par    <= 1'b0;
      par_oe <= 1'b0;
    end else begin
      par    <= ^{ad, be};
      par_oe <= drive;
    end
  end
endmodule

// File: rtl/pci_devsel_timer.sv
module pci_devsel_timer #(
  parameter int TO = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic watch,
  input  logic devsel_n,
  output logic timeout
);
  localparam int CW = $clog2(TO + 1);
  logic [CW-1:0] cnt;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (watch) begin
      if (!devsel_n)  seen <= 1'b1;
      else if (!seen) cnt  <= cnt + 1'b1;
    end
  end

  assign timeout = watch && !seen && devsel_n && (cnt == CW'(TO - 2));

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(TO - 1));
endmodule

// File: rtl/pci_rd_master.sv
module pci_rd_master
  import pci_rd_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DEVSEL_TO = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [31:0]      start_addr,
  input  logic [CNT_W-1:0] start_count,
  input  logic             start_cls,
  input  logic             cfg_burst_en,
  input  logic             cfg_desc_burst,
  input  logic             cfg_mult_sel,
  input  logic             cfg_ext_req,
  output logic             busy,
  output logic             req_n,
  input  logic             gnt_n,
  output logic             frame_n,
  output logic             irdy_n,
  output logic [3:0]       cbe_n,
  output logic [31:0]      ad_out,
  output logic             ad_oe,
  input  logic [31:0]      ad_in,
  output logic             par,
  output logic             par_oe,
  input  logic             trdy_n,
  input  logic             devsel_n,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             mabort
);
  mst_state_t       state;
  logic [31:0]      addr;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] left;
  logic             cls_tx;
  logic             burst_ok;
  logic [3:0]       cmd;
  logic             timeout;
  logic             comp;

  pci_rd_cmd_sel u_cmd (
    .cls_tx        (cls_tx),
    .cfg_burst_en  (cfg_burst_en),
    .cfg_desc_burst(cfg_desc_burst),
    .cfg_mult_sel  (cfg_mult_sel),
    .multi_dword   (rem > CNT_W'(1)),
    .burst_ok      (burst_ok),
    .cmd           (cmd)
  );

  pci_par_gen #(.AD_W(32), .BE_W(4)) u_par (
    .clk   (clk),
    .rst   (rst),
    .ad    (ad_out),
    .be    (cbe_n),
    .drive (ad_oe),
    .par   (par),
    .par_oe(par_oe)
  );

  pci_devsel_timer #(.TO(DEVSEL_TO)) u_dsel (
    .clk     (clk),
    .rst     (rst),
    .arm     (state == ST_ADDR),
    .watch   (state == ST_DATA),
    .devsel_n(devsel_n),
    .timeout (timeout)
  );

  assign comp = (state == ST_DATA) && !irdy_n && !trdy_n && !devsel_n;
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      req_n    <= 1'b1;
      frame_n  <= 1'b1;
      irdy_n   <= 1'b1;
      cbe_n    <= 4'hF;
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      mabort   <= 1'b0;
      addr     <= '0;
      rem      <= '0;
      left     <= '0;
      cls_tx   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      mabort   <= 1'b0;
      case (state)
        ST_IDLE: if (start && start_count != '0) begin
          addr   <= start_addr;
          rem    <= start_count;
          cls_tx <= start_cls;
          req_n  <= 1'b0;
          state  <= ST_ARB;
        end
        ST_ARB: if (!gnt_n) begin
          frame_n <= 1'b0;
          ad_oe   <= 1'b1;
          ad_out  <= {addr[31:2], 2'b00};
          cbe_n   <= cmd;
          left    <= burst_ok ? rem : CNT_W'(1);
          if (!cfg_ext_req) req_n <= 1'b1;
          state   <= ST_ADDR;
        end
        ST_ADDR: begin
          ad_oe   <= 1'b0;
          irdy_n  <= 1'b0;
          cbe_n   <= 4'h0;
          frame_n <= (left == CNT_W'(1));
          state   <= ST_DATA;
        end
        ST_DATA: begin
          if (timeout) begin
            frame_n <= 1'b1;
            irdy_n  <= 1'b1;
            req_n   <= 1'b1;
            cbe_n   <= 4'hF;
            mabort  <= 1'b1;
            rem     <= '0;
            state   <= ST_IDLE;
          end else if (comp) begin
            rd_valid <= 1'b1;
            rd_data  <= ad_in;
            addr     <= addr + 32'd4;
            rem      <= rem - 1'b1;
            left     <= left - 1'b1;
            if (left == CNT_W'(1)) begin
              irdy_n <= 1'b1;
              cbe_n  <= 4'hF;
              req_n  <= 1'b1;
              state  <= ST_TURN;
            end else if (left == CNT_W'(2)) begin
              frame_n <= 1'b1;
            end
          end
        end
        ST_TURN: begin
          if (rem != '0) begin
            req_n <= 1'b0;
            state <= ST_ARB;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  lane_all_chk: assert property (@(posedge clk) disable iff (rst)
    !irdy_n |-> cbe_n == 4'b0000);
  // R4
  irdy_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ad_oe) |-> !irdy_n);
  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> (ad_out[1:0] == 2'b00 && !frame_n));
  // R5
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!irdy_n && !trdy_n && !devsel_n));
  // R6
  frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(frame_n) && !mabort) |-> !irdy_n);
  // R9
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(frame_n) && !cfg_ext_req) |-> req_n);
  // R8
  tenure_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irdy_n) |-> req_n);
  // R10
  par_match_chk: assert property (@(posedge clk) disable iff (rst)
    par_oe |-> par == ^{$past(ad_out), $past(cbe_n)});
endmodule

// File: tb/test_pci_rd_master.sv
`timescale 1ns/1ps
module test_pci_rd_master;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [CNT_W-1:0] start_count = '0;
  logic start_cls = 1'b0, cfg_burst_en = 1'b0, cfg_desc_burst = 1'b0;
  logic cfg_mult_sel = 1'b0, cfg_ext_req = 1'b0;
  logic busy, req_n, frame_n, irdy_n, ad_oe, par, par_oe, rd_valid, done, mabort;
  logic [3:0] cbe_n;
  logic [31:0] ad_out, rd_data;
  logic gnt_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1;
  logic [31:0] ad_in = '0;

  always #5 clk = ~clk;

  pci_rd_master #(.CNT_W(CNT_W), .DEVSEL_TO(5)) i_pci_rd_master (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .start_count(start_count), .start_cls(start_cls),
    .cfg_burst_en(cfg_burst_en), .cfg_desc_burst(cfg_desc_burst),
    .cfg_mult_sel(cfg_mult_sel), .cfg_ext_req(cfg_ext_req), .busy(busy),
    .req_n(req_n), .gnt_n(gnt_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .par(par), .par_oe(par_oe), .trdy_n(trdy_n), .devsel_n(devsel_n),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .mabort(mabort));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[31:16]} + 32'h0101_0101;
  endfunction

  // target and monitor state
  int tgt_ws = 0, tgt_dly = 1;
  bit tact = 0;
  int dcnt = 0, wcnt = 0;
  logic [31:0] taddr = '0;
  logic prev_irdy = 1'b1, prev_frame = 1'b1;
  longint cyc = 0, addr_time = 0, abort_gap = 0;
  logic [31:0] base_al = '0;
  logic [3:0] exp_cmd = '0;
  bit chk_next = 0, par_exp = 0;
  int mon_k, mon_tx, mon_last, cmd_err, addr_err, irdy_err, par_err;
  int lane_err, data_err, req_err;
  bit got_done, got_abort;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      gnt_n = 1'b1; devsel_n = 1'b1; trdy_n = 1'b1; tact = 0;
    end else begin
      gnt_n = req_n;
      if (mabort) begin
        got_abort = 1; abort_gap = cyc - addr_time;
        tact = 0; devsel_n = 1'b1; trdy_n = 1'b1;
      end
      if (done) got_done = 1;
      if (tact) begin
        bit comp;
        dcnt++;
        comp = !prev_irdy && !trdy_n && !devsel_n;
        if (comp) begin
          taddr += 32'd4;
          wcnt = 0;
          if (prev_frame) mon_last++;
          else if (cfg_ext_req && req_n) req_err++;   // R9
        end
        if (comp && prev_frame) begin
          tact = 0; devsel_n = 1'b1; trdy_n = 1'b1;
        end else begin
          if (dcnt >= tgt_dly) devsel_n = 1'b0;
          if (!devsel_n) begin
            trdy_n = !(wcnt >= tgt_ws);
            wcnt++;
          end
        end
      end
      if (ad_oe && !frame_n) begin
        tact = 1; dcnt = 0; wcnt = 0; devsel_n = 1'b1; trdy_n = 1'b1;
        taddr = ad_out;
        mon_tx++; addr_time = cyc;
        if (cbe_n != exp_cmd) cmd_err++;                               // R2
        if (ad_out != base_al + 32'(4 * mon_k)) addr_err++;            // R3
        par_exp = ^{ad_out, cbe_n};
        if (cfg_ext_req ? req_n : !req_n) req_err++;                   // R9
        chk_next = 1;
      end else if (chk_next) begin
        chk_next = 0;
        if (irdy_n) irdy_err++;                                        // R4
        if (!par_oe || par != par_exp) par_err++;                      // R10
      end
      if (!irdy_n && cbe_n != 4'h0) lane_err++;                        // R4
      if (rd_valid) begin
        if (rd_data != mem(base_al + 32'(4 * mon_k))) data_err++;      // R5
        mon_k++;
      end
      ad_in = mem(taddr);
    end
    prev_irdy = irdy_n;
    prev_frame = frame_n;
  end

  task automatic run(input bit cls, be, db, mrm, ext, input int cnt, ws, dly, bit abrt);
    bit burst;
    @(negedge clk);
    start_cls = cls; cfg_burst_en = be; cfg_desc_burst = db;
    cfg_mult_sel = mrm; cfg_ext_req = ext;
    tgt_ws = ws; tgt_dly = dly;
    burst = be && (cls || db);
    exp_cmd = (burst && cls && cnt > 1) ? (mrm ? 4'b1100 : 4'b1110) : 4'b0110;
    start_addr = {12'h3C0, 12'(cyc), 6'h0, 2'(cyc)};
    base_al = {start_addr[31:2], 2'b00};
    start_count = CNT_W'(cnt);
    mon_k = 0; mon_tx = 0; mon_last = 0; cmd_err = 0; addr_err = 0;
    irdy_err = 0; par_err = 0; lane_err = 0; data_err = 0; req_err = 0;
    got_done = 0; got_abort = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(req_n == 1'b0, "R1 req after start", req_n, 0);
    for (int i = 0; i < 400 && !got_done && !got_abort; i++) @(negedge clk);
    @(negedge clk);
    if (abrt) begin
      chk(got_abort && mon_k == 0 && !busy, "R11 abort taken", got_abort, 1);
      chk(abort_gap == 5, "R11 abort clock", abort_gap, 5);
      chk(frame_n && irdy_n && req_n, "R11 bus released", {frame_n, irdy_n, req_n}, 7);
    end else begin
      chk(got_done && !got_abort && !busy, "R12 done", got_done, 1);
      chk(mon_k == cnt && data_err == 0, "R5 data", data_err, 0);
      chk(mon_tx == (burst ? 1 : cnt), "R7 transactions", mon_tx, burst ? 1 : cnt);
      chk(mon_last == mon_tx, "R6 R8 last phase with frame high", mon_last, mon_tx);
      chk(cmd_err == 0, "R2 command", cmd_err, 0);
      chk(addr_err == 0, "R3 address", addr_err, 0);
      chk(irdy_err == 0 && lane_err == 0, "R4 irdy and lanes", irdy_err + lane_err, 0);
      chk(req_err == 0, "R9 request release", req_err, 0);
      chk(par_err == 0, "R10 parity", par_err, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_n && frame_n && irdy_n && !ad_oe && !busy, "R1 reset state",
        {req_n, frame_n, irdy_n, ad_oe, busy}, 5'b11100);
    rst = 1'b0;
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 2; b++)
        for (int d = 0; d < 2; d++)
          for (int m = 0; m < 2; m++)
            for (int e = 0; e < 2; e++)
              for (int n = 1; n <= 3; n++)
                for (int w = 0; w < 2; w++)
                  run(c[0], b[0], d[0], m[0], e[0], n, w, 1, 0);
    run(1, 1, 0, 0, 0, 4, 0, 0, 0);
    run(1, 1, 0, 1, 1, 5, 2, 4, 0);   // R11 claimed in the last allowed clock
    run(0, 0, 0, 0, 0, 2, 0, 5, 1);   // R11 claimed one clock late
    run(1, 1, 1, 0, 1, 3, 0, 99, 1);  // R11 never claimed
    run(1, 1, 1, 1, 0, 2, 1, 1, 0);   // R12 normal job after an abort
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule